// File: doc/BRIEF.md
# Split Approximate Unsigned Multiplier

This block is a purely combinational unsigned multiplier that gives up a little accuracy in the lower half of the product to save gates. Each N-bit operand is cut into a high half and a low half. The two high halves are multiplied exactly. That exact path recodes the multiplier half with radix-4 Booth digits, turns each digit into a selected partial product, compresses the rows with a chain of 3:2 carry-save stages, and resolves the last two rows with a grouped carry-lookahead adder. The result forms the upper N product bits.

The lower N bits come from the two low halves only. Each bit below the top one is a single OR over the one-bit products whose indices sum to that bit position. The top lower bit comes from a small AND-OR stage that looks at the three most significant low-half bit pairs. The same stage also raises a compensation carry, which is added into the exact upper product. Products of a high half with a low half are never formed.

The block suits error-tolerant datapaths such as pixel scaling and filtering. There, a small bounded error in the low product bits is acceptable in exchange for fewer gates. It has no clock and no state: the product follows the operands combinationally.

Top module: `approx_split_mult`

## Requirements
- R1: With H = N/2, AH = A[N-1:H] and BH = B[N-1:H], the output bits P[2N-1:N] equal (AH*BH + C) mod 2^N. C is the compensation carry from R4.
- R2: With a = A[H-1:0] and b = B[H-1:0], each bit P[i] for 0 <= i <= N-2 is 1 exactly when some pair j, k with j + k = i and 0 <= j, k < H has a[j] = b[k] = 1.
- R3: Define the three pair terms t0 = a[H-1]&b[H-1], t1 = a[H-2]&b[H-2] and t2 = a[H-3]&b[H-3]. Bit P[N-1] is the OR of t0, t1 and t2.
- R4: The compensation carry C is 1 exactly when at least two of t0, t1 and t2 are 1. The upper half therefore exceeds AH*BH by at most one, and only when P[N-1] is 1.
- R5: Cross terms between a high half and a low half have no effect. When b = 0, P equals (AH*BH) << N for every value of a.
- R6: When a = 0 and b = 0, P equals the exact product (AH*BH) << N.
- R7: The exact part is correct for every high-half pair, including AH = BH = 2^H - 1. This covers every Booth window pattern and the top digit, which is never negative.
- R8: If either whole operand is zero, the product is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | Unsigned multiplicand |
| b_in | input | N | Unsigned multiplier; its high half is Booth-recoded |
| prod_out | output | 2N | Approximate product |

## Verification
The bench builds the block with N = 8, so each operand half is four bits wide. That size makes an exhaustive sweep of all 65536 operand pairs affordable, so every OR column, every AND-OR combination and every Booth window pattern is compared against an independent model. The same sweep also gives the mean, mean absolute and maximum absolute error against the exact product.

// File: rtl/pm_pkg.sv
package pm_pkg;

    // One radix-4 recoded digit: magnitude select and sign.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_sel_t;

    // Window {upper, middle, lower} -> digit in {-2,-1,0,+1,+2}
    function automatic booth_sel_t booth_decode(input logic [2:0] win);
        booth_sel_t s;
        s.one = win[0] ^ win[1];
        s.two = (win[2] & ~win[1] & ~win[0]) | (~win[2] & win[1] & win[0]);
        s.neg = win[2] & ~(win[1] & win[0]);
        return s;
    endfunction

    function automatic logic majority3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/pm_low_approx.sv
module pm_low_approx #(
    parameter int H = 4
) (
    input  logic [H-1:0]   a_lo,
    input  logic [H-1:0]   b_lo,
    output logic [2*H-2:0] low_bits,
    output logic           top_bit,
    output logic           comp_carry
);
    localparam int NCOL = 2 * H - 1;

    logic [2:0] pair_and;

    // One OR column per product weight, no AND array summation
    for (genvar i = 0; i < NCOL; i++) begin : g_col
        always_comb begin
            logic acc;
            acc = 1'b0;
            for (int j = 0; j < H; j++) begin
                if ((i - j) >= 0 && (i - j) < H)
                    acc = acc | (a_lo[j] & b_lo[i - j]);
            end
            low_bits[i] = acc;
        end
    end

    for (genvar m = 0; m < 3; m++) begin : g_pair
        assign pair_and[m] = a_lo[H-1-m] & b_lo[H-1-m];
    end

    assign top_bit    = |pair_and;
    assign comp_carry = pm_pkg::majority3(pair_and);

endmodule

// File: rtl/pm_booth_digit.sv
module pm_booth_digit #(
    parameter int AW = 4,
    parameter int OW = 8,
    parameter int SH = 0
) (
    input  logic [2:0]    win,
    input  logic [AW-1:0] mcand,
    output logic [OW-1:0] row,
    output logic          neg
);
    localparam int MW = AW + 1;

    pm_pkg::booth_sel_t sel;
    logic [MW-1:0] mag;
    logic [OW-1:0] mag_w;
    logic [OW-1:0] base;

    always_comb begin
        sel = pm_pkg::booth_decode(win);
        if (sel.two)
            mag = {mcand, 1'b0};
        else if (sel.one)
            mag = {1'b0, mcand};
        else
            mag = '0;
        mag_w = {{(OW-MW){1'b0}}, mag};
        // Negative rows are inverted here; the +1 goes to the correction row
        base  = sel.neg ? ~mag_w : mag_w;
        row   = base << SH;
    end

    assign neg = sel.neg;

endmodule

// File: rtl/pm_csa_row.sv
module pm_csa_row #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] car_o
);
    logic [W-1:0] maj;

    assign sum_o = in_x ^ in_y ^ in_z;
    assign maj   = (in_x & in_y) | (in_x & in_z) | (in_y & in_z);
    assign car_o = {maj[W-2:0], 1'b0};

endmodule

// File: rtl/pm_cla_adder.sv
module pm_cla_adder #(
    parameter int W   = 8,
    parameter int GRP = 4
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    output logic [W-1:0] sum_o
);
    localparam int NG = (W + GRP - 1) / GRP;

    logic [W-1:0] gen;
    logic [W-1:0] prp;

    assign gen = op_x & op_y;
    assign prp = op_x ^ op_y;

    always_comb begin
        logic [NG:0] gcar;
        logic        ggen;
        logic        gprp;
        logic        c;
        int          idx;
        gcar  = '0;
        sum_o = '0;
        for (int g = 0; g < NG; g++) begin
            // group generate / propagate look ahead of the in-group carries
            ggen = 1'b0;
            gprp = 1'b1;
            for (int k = 0; k < GRP; k++) begin
                idx = g * GRP + k;
                if (idx < W) begin
                    ggen = gen[idx] | (prp[idx] & ggen);
                    gprp = gprp & prp[idx];
                end
            end
            gcar[g+1] = ggen | (gprp & gcar[g]);
            c = gcar[g];
            for (int k = 0; k < GRP; k++) begin
                idx = g * GRP + k;
                if (idx < W) begin
                    sum_o[idx] = prp[idx] ^ c;
                    c = gen[idx] | (prp[idx] & c);
                end
            end
        end
    end

endmodule

// File: rtl/approx_split_mult.sv
module approx_split_mult #(
    parameter int N = 8
) (
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   b_in,
    output logic [2*N-1:0] prod_out
);
    localparam int H    = N / 2;
    localparam int W    = N;            // exact product width
    localparam int NDIG = H / 2 + 1;    // radix-4 digits incl. zero-extension
    localparam int BW   = 2 * NDIG + 1;
    localparam int NROW = NDIG + 2;     // digit rows + correction + compensation
    localparam int NSTG = NROW - 2;

    logic [H-1:0] a_hi, b_hi, a_lo, b_lo;
    assign a_hi = a_in[N-1:H];
    assign b_hi = b_in[N-1:H];
    assign a_lo = a_in[H-1:0];
    assign b_lo = b_in[H-1:0];

    // ---------------- inexact lower half ----------------
    logic [N-2:0] low_bits;
    logic         top_low;
    logic         comp_carry;

    pm_low_approx #(.H(H)) u_low (
        .a_lo       (a_lo),
        .b_lo       (b_lo),
        .low_bits   (low_bits),
        .top_bit    (top_low),
        .comp_carry (comp_carry)
    );

    // ---------------- exact upper half ----------------
    logic [BW-1:0]     b_ext;
    logic [NDIG-1:0]   neg_d;
    logic [NROW*W-1:0] rows_flat;
    logic [W-1:0]      corr_row;

    assign b_ext = {{(BW-H-1){1'b0}}, b_hi, 1'b0};

    for (genvar d = 0; d < NDIG; d++) begin : g_digit
        pm_booth_digit #(.AW(H), .OW(W), .SH(2*d)) u_dig (
            .win   (b_ext[2*d+2:2*d]),
            .mcand (a_hi),
            .row   (rows_flat[d*W +: W]),
            .neg   (neg_d[d])
        );
    end

    always_comb begin
        corr_row = '0;
        for (int d = 0; d < NDIG; d++)
            corr_row[2*d] = neg_d[d];
    end

    assign rows_flat[NDIG*W +: W]     = corr_row;
    assign rows_flat[(NDIG+1)*W +: W] = {{(W-1){1'b0}}, comp_carry};

    // Carry-save chain: every stage folds one more row into (sum, carry)
    logic [(NSTG+1)*W-1:0] sum_flat;
    logic [(NSTG+1)*W-1:0] car_flat;

    assign sum_flat[0 +: W] = rows_flat[0 +: W];
    assign car_flat[0 +: W] = rows_flat[W +: W];

    for (genvar s = 1; s <= NSTG; s++) begin : g_stage
        pm_csa_row #(.W(W)) u_csa (
            .in_x  (sum_flat[(s-1)*W +: W]),
            .in_y  (car_flat[(s-1)*W +: W]),
            .in_z  (rows_flat[(s+1)*W +: W]),
            .sum_o (sum_flat[s*W +: W]),
            .car_o (car_flat[s*W +: W])
        );
    end

    logic [W-1:0] upper;

    pm_cla_adder #(.W(W), .GRP(4)) u_cla (
        .op_x  (sum_flat[NSTG*W +: W]),
        .op_y  (car_flat[NSTG*W +: W]),
        .sum_o (upper)
    );

    assign prod_out = {upper, top_low, low_bits};

endmodule

// File: rtl/pm_mult_checker.sv
module pm_mult_checker #(
    parameter int N = 8
) (
    input logic [N-1:0]   a_in,
    input logic [N-1:0]   b_in,
    input logic [2*N-1:0] prod_out
);
    localparam int H = N / 2;

    logic [N-1:0] hi_prod;
    logic [N-1:0] up_diff;

    assign hi_prod = N'(a_in[N-1:H]) * N'(b_in[N-1:H]);
    assign up_diff = prod_out[2*N-1:N] - hi_prod;

    always_comb begin
        if (a_in[H-1:0] == '0 && b_in[H-1:0] == '0)
            assert_upper_exact_R6: assert (prod_out == {hi_prod, {N{1'b0}}})
                else $error("upper half not exact with zero low halves");
        assert_comp_bound_R4: assert (up_diff <= N'(1))
            else $error("compensation exceeds one unit");
        if (!prod_out[N-1])
            assert_comp_gate_R4: assert (up_diff == '0)
                else $error("compensation without top low bit");
        if (a_in[H-1:0] == '0 || b_in[H-1:0] == '0)
            assert_low_zero_R2: assert (prod_out[N-2:0] == '0)
                else $error("low bits set without low-half terms");
        if (a_in == '0 || b_in == '0)
            assert_zero_R8: assert (prod_out == '0)
                else $error("zero operand gave nonzero product");
    end

endmodule

bind approx_split_mult pm_mult_checker #(.N(N)) u_chk (
    .a_in     (a_in),
    .b_in     (b_in),
    .prod_out (prod_out)
);

// File: tb/sim_approx_split_mult.sv
module sim_approx_split_mult;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic [N-1:0] a_in = '0;
    logic [N-1:0] b_in = '0;
    logic [2*N-1:0] prod_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    approx_split_mult #(.N(N)) u0 (
        .a_in     (a_in),
        .b_in     (b_in),
        .prod_out (prod_out)
    );

    // {A, B, expected P}, worked out by hand from the requirements
    localparam int NVEC = 10;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 16'h0000},   // R8 zero
        {8'hFF, 8'hFF, 16'hE2FF},   // R4 carry added, R2 all columns
        {8'hF0, 8'hF0, 16'hE100},   // R7 largest high halves
        {8'h0F, 8'hF0, 16'h0000},   // R5 cross term ignored
        {8'h3C, 8'h5A, 16'h0FF8},   // R3 single pair term
        {8'h86, 8'h46, 16'h219C},   // R4 two pair terms
        {8'h71, 8'h91, 16'h3F01},   // R2 lsb only
        {8'hA5, 8'h3F, 16'h1EBF},   // R2 wide OR columns
        {8'hCE, 8'hB0, 16'h8400},   // R5 b low zero
        {8'h6A, 8'h2A, 16'h0DD4}    // R1 upper with carry
    };
    localparam string TAG [NVEC] = '{
        "R8", "R4", "R7", "R5", "R3", "R4", "R2", "R2", "R5", "R1"
    };

    function automatic logic [15:0] ref_prod(input logic [7:0] a, input logic [7:0] b);
        logic [3:0] al = a[3:0];
        logic [3:0] bl = b[3:0];
        logic [7:0] lo = '0;
        logic [7:0] up;
        logic t0, t1, t2, cc;
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 4; j++)
                if ((i - j) >= 0 && (i - j) < 4 && al[j] && bl[i - j])
                    lo[i] = 1'b1;
        t0 = al[3] & bl[3];
        t1 = al[2] & bl[2];
        t2 = al[1] & bl[1];
        lo[7] = t0 | t1 | t2;
        cc = (t0 & t1) | (t0 & t2) | (t1 & t2);
        up = 8'(a[7:4]) * 8'(b[7:4]) + 8'(cc);
        return {up, lo};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s A=%h B=%h got=%h expected=%h", req, a_in, b_in, got, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        a_in = a;
        b_in = b;
        @(posedge clk);
        #2;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        real  sum_err, sum_abs, max_abs, e;
        sum_err = 0.0;
        sum_abs = 0.0;
        max_abs = 0.0;

        // idle state: operands at zero give a zero product (R8)
        apply(8'h00, 8'h00);
        check("R8", prod_out, 16'h0000);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][31:24], VEC[v][23:16]);
            check(TAG[v], prod_out, VEC[v][15:0]);
        end

        // R5: low half of A swept while B low half is zero
        for (int x = 0; x < 16; x++) begin
            apply({4'h9, 4'(x)}, 8'h70);
            check("R5", prod_out, 16'h3F00);
        end

        // R6 / R7: every high-half pair with zero low halves
        for (int ah = 0; ah < 16; ah++)
            for (int bh = 0; bh < 16; bh++) begin
                apply({4'(ah), 4'h0}, {4'(bh), 4'h0});
                check("R7", prod_out, {8'(ah * bh), 8'h00});
            end

        // R8: one zero operand against a full one
        apply(8'h00, 8'hFF);
        check("R8", prod_out, 16'h0000);
        apply(8'hFF, 8'h00);
        check("R8", prod_out, 16'h0000);

        // R1 R2 R3 R4: exhaustive compare with the model, plus error figures
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++) begin
                apply(8'(a), 8'(b));
                check("R1_R2_R3_R4", prod_out, ref_prod(8'(a), 8'(b)));
                e = real'(int'(prod_out)) - real'(a * b);
                sum_err += e;
                sum_abs += (e < 0.0) ? -e : e;
                if (((e < 0.0) ? -e : e) > max_abs) max_abs = (e < 0.0) ? -e : e;
            end

        $display("error vs exact: mean %f, mean abs %f, max abs %f",
                 sum_err / 65536.0, sum_abs / 65536.0, max_abs);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule